// File: doc/BRIEF.md
# Unlock-Gated Configuration Window for a Disk Channel

This block sits between a host-side I/O strobe port and the task-file registers of a disk channel. It has eight byte offsets. Normally every access passes straight through to the drive register path. A fixed sequence of ordinary-looking accesses switches the window into a hidden configuration mode. In that mode the same offsets reach the controller's own registers: two banks of read and write cycle timing, a control byte, a read-only strap/version byte and a miscellaneous byte that picks the timing bank.

Software opens the window with two back-to-back word reads at offset 1, followed by a byte write of 3 at offset 2. It programs the timing bytes of each bank, chooses which bank each drive uses, and then closes the window with a byte write of 0x83 at offset 2. The block presents the timing bytes that apply to drive 0 and drive 1 as steady outputs for the timing generator, which lies outside this block.

Top module: `ide_cfg_gate`

## Requirements
- R1: During reset and right after it, configuration mode is closed. All four drive timing outputs and `misc_q` are 0, and the tracker is idle.
- R2: While configuration mode is closed, `drv_rd` follows a read (`bus_rd` with `bus_wr` low) and `drv_wr` follows `bus_wr`. `drv_addr` and `drv_wdata` mirror the bus, and `bus_rdata` equals `drv_rdata`.
- R3: Configuration mode opens on the clock after a byte write (`bus_byte`=1) of value 3 at offset 2 that follows at least two consecutive word reads (`bus_byte`=0) at offset 1. Cycles with no strobe do not count as accesses.
- R4: Any other access resets the unlock tracker to idle. This includes a read at another offset, a byte read at offset 1, a wrong value, a word-wide write of 3 and a write at another offset. The tracker also resets after a successful unlock.
- R5: While configuration mode is open, `drv_rd` and `drv_wr` stay low.
- R6: In configuration mode, a byte write of 0x83 at offset 2 closes the mode on the next clock. Other values, and a word-wide write of 0x83, leave it open.
- R7: In configuration mode, offset 0 reads and writes the read-cycle timing byte of the selected bank, and offset 1 the write-cycle timing byte. Register data is carried in bits 7:0 and the upper bus bits read as 0.
- R8: A write to offset 6 in configuration mode sets the bank select to bit 0 of the written byte (0 = bank A, 1 = bank B), but only if bank B is enabled. Bank B is enabled when the most recent write at offset 3 made while the mode was closed carried 0xC0. Otherwise bank A is selected.
- R9: Offset 3 in configuration mode is the control byte, read and write. While it holds 0x85, drive 1 uses bank B timing. Drive 0 always uses bank A, and any other value gives drive 1 bank A as well.
- R10: Offset 5 reads the strap value (default 0), and writes there are ignored. Offset 6 reads back the miscellaneous byte, which is also driven on `misc_q`.
- R11: While the mode is closed, no write changes any configuration register. The values survive closing and reopening.
- R12: In configuration mode, offsets 2, 4 and 7 read as 0, and writes there have no effect other than the close command of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Offset within the window |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe, wins over read |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| bus_rdata | output | 16 | Read data |
| drv_addr | output | 3 | Offset to drive registers |
| drv_wdata | output | 16 | Write data to drive registers |
| drv_rd | output | 1 | Read strobe to drive registers |
| drv_wr | output | 1 | Write strobe to drive registers |
| drv_rdata | input | 16 | Read data from drive registers |
| cfg_mode | output | 1 | Configuration mode open |
| drv0_rtim | output | 8 | Read timing applied to drive 0 |
| drv0_wtim | output | 8 | Write timing applied to drive 0 |
| drv1_rtim | output | 8 | Read timing applied to drive 1 |
| drv1_wtim | output | 8 | Write timing applied to drive 1 |
| misc_q | output | 8 | Miscellaneous byte |

## Verification
A tracker stuck in the wrong state appears on `cfg_mode` one clock after the closing byte write of a sequence. If the mode is wrongly left open, the drive strobes stay low within the same cycle as the next access. A wrong bank select or a lost bank-B enable shows up as a wrong byte on the timing outputs one clock after the timing write. It also shows on the very next configuration read at offset 0 or 1. Comparing every output against a behavioural model on every cycle therefore finds such faults within one or two accesses of their cause.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 16;
    localparam int REG_W  = 8;
    localparam int NBANK  = 2;

    localparam logic [ADDR_W-1:0] OFF_RTIM  = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_WTIM  = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_PROBE = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_KEY   = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_STRAP = 3'd5;
    localparam logic [ADDR_W-1:0] OFF_MISC  = 3'd6;

    typedef enum logic [1:0] {
        TRK_IDLE = 2'd0,
        TRK_ONE  = 2'd1,
        TRK_TWO  = 2'd2
    } trk_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic              narrow;
        logic [ADDR_W-1:0] off;
        logic [REG_W-1:0]  lo;
    } acc_t;

    typedef struct packed {
        logic [REG_W-1:0] rtim;
        logic [REG_W-1:0] wtim;
    } bank_t;

    function automatic acc_t decode_bus(input logic rd, input logic wr, input logic narrow,
                                        input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] d);
        acc_t x;
        x.wr     = wr;
        x.rd     = rd & ~wr;
        x.narrow = narrow;
        x.off    = a;
        x.lo     = d;
        return x;
    endfunction

    function automatic logic is_key_write(input acc_t x, input logic [ADDR_W-1:0] o,
                                          input logic [REG_W-1:0] v);
        return x.wr && x.narrow && (x.off == o) && (x.lo == v);
    endfunction

    function automatic logic is_probe_read(input acc_t x);
        return x.rd && !x.narrow && (x.off == OFF_PROBE);
    endfunction

    function automatic trk_e trk_advance(input trk_e s);
        return (s == TRK_IDLE) ? TRK_ONE : TRK_TWO;
    endfunction

endpackage

// File: rtl/ide_cfg_unlock.sv
module ide_cfg_unlock
    import ide_cfg_pkg::*;
#(
    parameter logic [REG_W-1:0] OPEN_KEY  = 8'h03,
    parameter logic [REG_W-1:0] CLOSE_KEY = 8'h83
) (
    input  logic clk,
    input  logic rst,
    input  acc_t acc,
    output logic cfg_mode
);
    trk_e trk_q, trk_d;
    logic cfg_q, cfg_d;
    logic active;

    assign active = acc.rd | acc.wr;

    always_comb begin
        trk_d = trk_q;
        cfg_d = cfg_q;
        if (active) begin
            if (cfg_q) begin
                trk_d = TRK_IDLE;
                if (is_key_write(acc, OFF_KEY, CLOSE_KEY)) begin
                    cfg_d = 1'b0;
                end
            end else if (is_probe_read(acc)) begin
                trk_d = trk_advance(trk_q);
            end else begin
                trk_d = TRK_IDLE;
                if ((trk_q == TRK_TWO) && is_key_write(acc, OFF_KEY, OPEN_KEY)) begin
                    cfg_d = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q <= TRK_IDLE;
            cfg_q <= 1'b0;
        end else begin
            trk_q <= trk_d;
            cfg_q <= cfg_d;
        end
    end

    assign cfg_mode = cfg_q;
endmodule

// File: rtl/ide_cfg_regfile.sv
module ide_cfg_regfile
    import ide_cfg_pkg::*;
#(
    parameter logic [REG_W-1:0] BANKB_KEY = 8'hC0,
    parameter logic [REG_W-1:0] MAP_KEY   = 8'h85,
    parameter logic [REG_W-1:0] STRAP_VAL = 8'h00
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_mode,
    input  acc_t             acc,
    output logic [REG_W-1:0] cfg_rdata,
    output bank_t            drv0_tim,
    output bank_t            drv1_tim,
    output logic [REG_W-1:0] misc_q
);
    localparam int SEL_W = $clog2(NBANK);

    bank_t             bank_rd [NBANK];
    logic [SEL_W-1:0]  sel_q;
    logic              bb_en_q;
    logic [REG_W-1:0]  ctrl_q;
    logic [REG_W-1:0]  misc_r;
    logic              cfg_wr;
    logic              open_wr;

    assign cfg_wr  = cfg_mode & acc.wr;
    assign open_wr = ~cfg_mode & acc.wr;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bank_t q;
        logic  hit;
        assign hit = cfg_wr && (32'(sel_q) == b);
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (hit) begin
                if (acc.off == OFF_RTIM) q.rtim <= acc.lo;
                if (acc.off == OFF_WTIM) q.wtim <= acc.lo;
            end
        end
        assign bank_rd[b] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            bb_en_q <= 1'b0;
            ctrl_q  <= '0;
            misc_r  <= '0;
        end else begin
            if (open_wr && (acc.off == OFF_CTRL)) begin
                bb_en_q <= (acc.lo == BANKB_KEY);
            end
            if (cfg_wr && (acc.off == OFF_CTRL)) begin
                ctrl_q <= acc.lo;
            end
            if (cfg_wr && (acc.off == OFF_MISC)) begin
                misc_r <= acc.lo;
                sel_q  <= SEL_W'(acc.lo[0] & bb_en_q);
            end
        end
    end

    always_comb begin
        case (acc.off)
            OFF_RTIM:  cfg_rdata = bank_rd[sel_q].rtim;
            OFF_WTIM:  cfg_rdata = bank_rd[sel_q].wtim;
            OFF_CTRL:  cfg_rdata = ctrl_q;
            OFF_STRAP: cfg_rdata = STRAP_VAL;
            OFF_MISC:  cfg_rdata = misc_r;
            default:   cfg_rdata = '0;
        endcase
    end

    assign drv0_tim = bank_rd[0];
    assign drv1_tim = (ctrl_q == MAP_KEY) ? bank_rd[NBANK-1] : bank_rd[0];
    assign misc_q   = misc_r;
endmodule

// File: rtl/ide_cfg_route.sv
module ide_cfg_route
    import ide_cfg_pkg::*;
(
    input  logic              cfg_mode,
    input  acc_t              acc,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [REG_W-1:0]  cfg_rdata,
    input  logic [DATA_W-1:0] drv_rdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] drv_addr,
    output logic [DATA_W-1:0] drv_wdata,
    output logic              drv_rd,
    output logic              drv_wr
);
    assign drv_rd    = acc.rd & ~cfg_mode;
    assign drv_wr    = acc.wr & ~cfg_mode;
    assign drv_addr  = bus_addr;
    assign drv_wdata = bus_wdata;
    assign bus_rdata = cfg_mode ? DATA_W'(cfg_rdata) : drv_rdata;
endmodule

// File: rtl/ide_cfg_gate.sv
module ide_cfg_gate
    import ide_cfg_pkg::*;
#(
    parameter logic [REG_W-1:0] OPEN_KEY  = 8'h03,
    parameter logic [REG_W-1:0] CLOSE_KEY = 8'h83,
    parameter logic [REG_W-1:0] BANKB_KEY = 8'hC0,
    parameter logic [REG_W-1:0] MAP_KEY   = 8'h85,
    parameter logic [REG_W-1:0] STRAP_VAL = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_byte,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] drv_addr,
    output logic [DATA_W-1:0] drv_wdata,
    output logic              drv_rd,
    output logic              drv_wr,
    input  logic [DATA_W-1:0] drv_rdata,
    output logic              cfg_mode,
    output logic [REG_W-1:0]  drv0_rtim,
    output logic [REG_W-1:0]  drv0_wtim,
    output logic [REG_W-1:0]  drv1_rtim,
    output logic [REG_W-1:0]  drv1_wtim,
    output logic [REG_W-1:0]  misc_q
);
    acc_t             acc;
    logic [REG_W-1:0] cfg_rdata;
    bank_t            d0_tim, d1_tim;

    assign acc = decode_bus(bus_rd, bus_wr, bus_byte, bus_addr, bus_wdata[REG_W-1:0]);

    ide_cfg_unlock #(.OPEN_KEY(OPEN_KEY), .CLOSE_KEY(CLOSE_KEY)) unlock_i (
        .clk(clk), .rst(rst), .acc(acc), .cfg_mode(cfg_mode)
    );

    ide_cfg_regfile #(.BANKB_KEY(BANKB_KEY), .MAP_KEY(MAP_KEY), .STRAP_VAL(STRAP_VAL)) regs_i (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .acc(acc),
        .cfg_rdata(cfg_rdata), .drv0_tim(d0_tim), .drv1_tim(d1_tim), .misc_q(misc_q)
    );

    ide_cfg_route route_i (
        .cfg_mode(cfg_mode), .acc(acc), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .cfg_rdata(cfg_rdata), .drv_rdata(drv_rdata), .bus_rdata(bus_rdata),
        .drv_addr(drv_addr), .drv_wdata(drv_wdata), .drv_rd(drv_rd), .drv_wr(drv_wr)
    );

    assign drv0_rtim = d0_tim.rtim;
    assign drv0_wtim = d0_tim.wtim;
    assign drv1_rtim = d1_tim.rtim;
    assign drv1_wtim = d1_tim.wtim;
endmodule

// File: rtl/ide_cfg_gate_chk.sv
module ide_cfg_gate_chk
    import ide_cfg_pkg::*;
#(
    parameter logic [REG_W-1:0] OPEN_KEY  = 8'h03,
    parameter logic [REG_W-1:0] CLOSE_KEY = 8'h83,
    parameter logic [REG_W-1:0] STRAP_VAL = 8'h00
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              bus_byte,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              drv_rd,
    input logic              drv_wr,
    input logic [DATA_W-1:0] drv_rdata,
    input logic              cfg_mode,
    input logic [REG_W-1:0]  drv0_rtim,
    input logic [REG_W-1:0]  drv0_wtim,
    input logic [REG_W-1:0]  drv1_rtim,
    input logic [REG_W-1:0]  drv1_wtim,
    input logic [REG_W-1:0]  misc_q
);
    logic open_wr, close_wr, plain_rd, gap_off;
    assign open_wr  = bus_wr && bus_byte && (bus_addr == OFF_KEY) && (bus_wdata[REG_W-1:0] == OPEN_KEY);
    assign close_wr = bus_wr && bus_byte && (bus_addr == OFF_KEY) && (bus_wdata[REG_W-1:0] == CLOSE_KEY);
    assign plain_rd = bus_rd && !bus_wr;
    assign gap_off  = (bus_addr == 3'd2) || (bus_addr == 3'd4) || (bus_addr == 3'd7);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (!cfg_mode && drv0_rtim == '0 && drv1_wtim == '0 && misc_q == '0)); // R1
    AST_PASS_DATA: assert property (@(posedge clk) disable iff (rst) (!cfg_mode && plain_rd) |-> (bus_rdata == drv_rdata)); // R2
    AST_OPEN_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(cfg_mode) |-> $past(open_wr)); // R3
    AST_DRV_QUIET: assert property (@(posedge clk) disable iff (rst) cfg_mode |-> (!drv_rd && !drv_wr)); // R5
    AST_CLOSE_CAUSE: assert property (@(posedge clk) disable iff (rst) $fell(cfg_mode) |-> $past(close_wr)); // R6
    AST_CLOSE_TAKES: assert property (@(posedge clk) disable iff (rst) (cfg_mode && close_wr) |=> !cfg_mode); // R6
    AST_STRAP_READ: assert property (@(posedge clk) disable iff (rst) (cfg_mode && bus_addr == OFF_STRAP) |-> (bus_rdata == DATA_W'(STRAP_VAL))); // R10
    AST_HOLD_CLOSED: assert property (@(posedge clk) disable iff (rst) !cfg_mode |=> ($stable(drv0_rtim) && $stable(drv0_wtim) && $stable(drv1_rtim) && $stable(drv1_wtim) && $stable(misc_q))); // R11
    AST_GAP_ZERO: assert property (@(posedge clk) disable iff (rst) (cfg_mode && gap_off) |-> (bus_rdata == '0)); // R12
endmodule

bind ide_cfg_gate ide_cfg_gate_chk #(.OPEN_KEY(OPEN_KEY), .CLOSE_KEY(CLOSE_KEY), .STRAP_VAL(STRAP_VAL)) chk_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_byte(bus_byte), .bus_rdata(bus_rdata), .drv_rd(drv_rd),
    .drv_wr(drv_wr), .drv_rdata(drv_rdata), .cfg_mode(cfg_mode), .drv0_rtim(drv0_rtim),
    .drv0_wtim(drv0_wtim), .drv1_rtim(drv1_rtim), .drv1_wtim(drv1_wtim), .misc_q(misc_q)
);

// File: tb/ide_cfg_gate_tb_top.sv
module ide_cfg_gate_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_byte = 1'b0;
    logic [15:0] bus_rdata, drv_wdata, drv_rdata;
    logic [2:0]  drv_addr;
    logic        drv_rd, drv_wr, cfg_mode;
    logic [7:0]  drv0_rtim, drv0_wtim, drv1_rtim, drv1_wtim, misc_q;

    int    errs = 0;
    int    checks = 0;
    int    cyc = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign drv_rdata = 16'(cyc * 37) ^ 16'h5A0F;

    ide_cfg_gate dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_byte(bus_byte), .bus_rdata(bus_rdata), .drv_addr(drv_addr),
        .drv_wdata(drv_wdata), .drv_rd(drv_rd), .drv_wr(drv_wr), .drv_rdata(drv_rdata),
        .cfg_mode(cfg_mode), .drv0_rtim(drv0_rtim), .drv0_wtim(drv0_wtim),
        .drv1_rtim(drv1_rtim), .drv1_wtim(drv1_wtim), .misc_q(misc_q)
    );

    // Behavioural reference model
    bit         m_cfg = 0, m_bb = 0, m_sel = 0;
    int         m_cnt = 0;
    logic [7:0] m_rt[2] = '{8'h00, 8'h00};
    logic [7:0] m_wt[2] = '{8'h00, 8'h00};
    logic [7:0] m_ctrl = '0, m_misc = '0;

    always @(posedge clk) begin
        logic [7:0] v;
        v = bus_wdata[7:0];
        if (rst) begin
            m_cfg = 0; m_bb = 0; m_sel = 0; m_cnt = 0;
            m_rt[0] = 0; m_rt[1] = 0; m_wt[0] = 0; m_wt[1] = 0; m_ctrl = 0; m_misc = 0;
        end else if (bus_rd || bus_wr) begin
            if (m_cfg) begin
                m_cnt = 0;
                if (bus_wr) begin
                    case (bus_addr)
                        3'd0: m_rt[m_sel] = v;
                        3'd1: m_wt[m_sel] = v;
                        3'd2: if (bus_byte && v == 8'h83) m_cfg = 0;
                        3'd3: m_ctrl = v;
                        3'd6: begin m_misc = v; m_sel = v[0] & m_bb; end
                        default: ;
                    endcase
                end
            end else begin
                if (bus_wr && bus_addr == 3'd3) m_bb = (v == 8'hC0);
                if (!bus_wr && !bus_byte && bus_addr == 3'd1) begin
                    m_cnt = (m_cnt < 2) ? m_cnt + 1 : 2;
                end else begin
                    if (bus_wr && bus_byte && bus_addr == 3'd2 && v == 8'h03 && m_cnt == 2) m_cfg = 1;
                    m_cnt = 0;
                end
            end
        end
    end

    task automatic chk(input string nm, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, nm, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            logic [15:0] exp_rd;
            logic [7:0]  cv;
            case (bus_addr)
                3'd0: cv = m_rt[m_sel];
                3'd1: cv = m_wt[m_sel];
                3'd3: cv = m_ctrl;
                3'd5: cv = 8'h00;
                3'd6: cv = m_misc;
                default: cv = 8'h00;
            endcase
            exp_rd = m_cfg ? {8'h00, cv} : drv_rdata;
            chk("cfg_mode", 16'(cfg_mode), 16'(m_cfg));
            chk("drv_rd", 16'(drv_rd), 16'(!m_cfg && bus_rd && !bus_wr));
            chk("drv_wr", 16'(drv_wr), 16'(!m_cfg && bus_wr));
            chk("drv_addr", 16'(drv_addr), 16'(bus_addr));
            chk("drv_wdata", drv_wdata, bus_wdata);
            chk("bus_rdata", bus_rdata, exp_rd);
            chk("drv0_rtim", 16'(drv0_rtim), 16'(m_rt[0]));
            chk("drv0_wtim", 16'(drv0_wtim), 16'(m_wt[0]));
            chk("drv1_rtim", 16'(drv1_rtim), 16'((m_ctrl == 8'h85) ? m_rt[1] : m_rt[0]));
            chk("drv1_wtim", 16'(drv1_wtim), 16'((m_ctrl == 8'h85) ? m_wt[1] : m_wt[0]));
            chk("misc_q", 16'(misc_q), 16'(m_misc));
        end
    end

    task automatic acc(input logic r, input logic w, input logic b, input logic [2:0] a, input logic [15:0] d);
        bus_rd = r; bus_wr = w; bus_byte = b; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_rd = 0; bus_wr = 0;
    endtask
    task automatic rdw(input logic [2:0] a); acc(1, 0, 0, a, 16'h0); endtask
    task automatic rdb(input logic [2:0] a); acc(1, 0, 1, a, 16'h0); endtask
    task automatic wrb(input logic [2:0] a, input logic [15:0] d); acc(0, 1, 1, a, d); endtask
    task automatic wrw(input logic [2:0] a, input logic [15:0] d); acc(0, 1, 0, a, d); endtask
    task automatic idle(input int n); repeat (n) begin @(posedge clk); #1; end endtask
    task automatic unlock(); rdw(1); rdw(1); wrb(2, 16'h0003); endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        cur_req = "R1"; idle(2);
        cur_req = "R2"; wrw(0, 16'h1234); rdw(1); rdb(7); wrb(3, 16'h00AA); rdw(5); rdw(2);
        cur_req = "R11"; wrb(0, 16'h0077); wrb(1, 16'h0066); wrb(6, 16'h0001); idle(1);
        cur_req = "R4";
        rdw(1); rdw(0); rdw(1); wrb(2, 16'h0003); idle(1);
        rdw(1); rdb(1); rdw(1); wrb(2, 16'h0003); idle(1);
        rdw(1); rdw(1); wrb(2, 16'h0004); idle(1);
        rdw(1); rdw(1); wrw(2, 16'h0003); idle(1);
        rdw(1); rdw(1); wrb(3, 16'h0003); idle(1);
        rdw(1); rdw(1); rdw(2); wrb(2, 16'h0003); idle(1);
        cur_req = "R3"; rdw(1); idle(2); rdw(1); wrb(2, 16'h0003); idle(1);
        cur_req = "R8"; wrb(6, 16'h0001); wrb(0, 16'h0011); wrb(1, 16'h0022); rdw(0); rdw(1);
        cur_req = "R5"; rdw(0); wrw(1, 16'h0022);
        cur_req = "R6"; wrb(2, 16'h0055); idle(1); wrw(2, 16'h0083); idle(1); wrb(2, 16'h0083); idle(1);
        cur_req = "R8"; wrb(3, 16'h00C0);
        cur_req = "R3"; rdw(1); rdw(1); rdw(1); wrb(2, 16'h0003); idle(1);
        cur_req = "R7";
        wrb(6, 16'h0000); wrb(0, 16'h0031); wrb(1, 16'h0042);
        wrb(6, 16'h0001); wrb(0, 16'h005A); wrb(1, 16'h006B); rdw(0); rdw(1);
        wrb(6, 16'h0000); rdw(0); rdw(1);
        cur_req = "R9"; rdw(3); wrb(3, 16'h0085); rdw(3); idle(1); wrb(3, 16'h0084); idle(1); wrb(3, 16'h0085); idle(1);
        cur_req = "R10"; rdw(5); wrb(5, 16'h00FF); rdw(5); wrb(6, 16'h00C4); rdw(6); rdw(0);
        cur_req = "R12"; rdw(2); rdw(4); rdw(7); wrb(4, 16'h0099); wrb(7, 16'h0088); rdw(0); rdw(3);
        cur_req = "R6"; wrb(2, 16'h0083); idle(1);
        cur_req = "R11"; wrb(0, 16'h00EE); wrb(1, 16'h00DD); wrb(6, 16'h0001); wrb(3, 16'h0000); idle(2);
        cur_req = "R3"; unlock(); idle(1);
        cur_req = "R11"; rdw(0); rdw(1); rdw(3); rdw(6); rdw(5);
        cur_req = "R6"; wrb(2, 16'h0083); idle(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            errs++; checks++;
            $display("FAIL watchdog %s: actual timeout expected completion", cur_req);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule